// File: doc/BRIEF.md
# Dual-Channel Interleaved Sample Input Pipeline

This block is the digital front end of a two-channel sample converter. It accepts one sample word per channel and per conversion clock, and presents two registered channel codes that always change together on a rising edge. In parallel operation each channel has its own input bus. Both buses are captured on the rising edge, and the pair reaches the outputs one rising edge later.

In interleaved operation the two channels share the first bus, which halves the pin count. The word present at a falling edge is taken as the channel-1 sample. The word present at the following rising edge is taken as the channel-0 sample. The pair is applied to both outputs together on the next rising edge, and the second bus is unused.

An output enable from the mode controller freezes the output codes while the converter is in standby or power-down. A one-cycle update strobe marks every cycle in which the output pair was reloaded.

Top module: `twin_sample_front`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `code0`, `code1` and `upd` to zero.
- R2: With `il_mode` = 0 and `out_en` = 1, the values on `bus0` and `bus1` at rising edge k appear on `code0` and `code1` after rising edge k+1, which is one clock of latency.
- R3: In parallel operation with a new pair on every clock, each rising edge shows the pair captured at the rising edge before it, so no pair is skipped or repeated.
- R4: With `il_mode` = 1, the value on `bus0` at a falling edge becomes the next `code1`.
- R5: With `il_mode` = 1, the value on `bus0` at the rising edge after that falling edge becomes `code0`. Both codes take their new values on the rising edge that follows.
- R6: With `il_mode` = 1, `bus1` has no effect on either output code.
- R7: While `out_en` is 0 at a rising edge, `code0` and `code1` keep their values and `upd` is 0 after that edge.
- R8: `upd` is 1 after a rising edge exactly when `out_en` was 1 at that edge and at least one capture has occurred since reset. After reset is released, the first strobe comes one clock after the first capture.
- R9: `code0` and `code1` never change on a falling edge. The falling-edge sample is staged internally until the rising-edge update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; rising and falling edges both sample |
| rst | input | 1 | Synchronous active-high reset |
| il_mode | input | 1 | 0 = parallel buses, 1 = both channels interleaved on `bus0` |
| out_en | input | 1 | 1 = outputs update; 0 = hold (standby or power-down) |
| bus0 | input | W (8) | Channel-0 bus; also carries channel-1 samples when interleaved |
| bus1 | input | W (8) | Channel-1 bus, used only in parallel operation |
| code0 | output | W (8) | Registered channel-0 output code |
| code1 | output | W (8) | Registered channel-1 output code |
| upd | output | 1 | High for one cycle after each output reload |

## Verification
A wrong value in the falling-edge staging register shows up only on `code1`, and only in interleaved mode, one rising edge after the pair is captured. A staging path that leaks straight through to the outputs shows up as an output change at a falling edge, which the bench samples just after every falling edge. A wrong capture register corrupts both codes two rising edges after the word was driven. A wrong enable or valid flag shows at once on `upd`, or as an output that moves during standby on the first edge after `out_en` drops.

// File: rtl/twin_sample_pkg.sv
package twin_sample_pkg;
  localparam int DEF_SAMPLE_W = 8;

  typedef enum logic {
    LANE_PARALLEL = 1'b0,
    LANE_SHARED   = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/twin_sample_capture.sv
module twin_sample_capture
  import twin_sample_pkg::*;
#(
  parameter int W = DEF_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         il_mode,
  input  logic [W-1:0] bus0,
  input  logic [W-1:0] bus1,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic         cap_vld
);
  logic [W-1:0] stage_b;
  lane_mode_e   mode;

  assign mode = lane_mode_e'(il_mode);

  // Falling-edge staging of the shared-bus channel-1 word
  always_ff @(negedge clk) begin
    if (rst) stage_b <= '0;
    else     stage_b <= bus0;
  end

  // Rising-edge capture of the pair
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a   <= '0;
      cap_b   <= '0;
      cap_vld <= 1'b0;
    end else begin
      cap_a   <= bus0;
      cap_b   <= (mode == LANE_SHARED) ? stage_b : bus1;
      cap_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/twin_sample_outreg.sv
module twin_sample_outreg
  import twin_sample_pkg::*;
#(
  parameter int W = DEF_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_en,
  input  logic [W-1:0] cap_a,
  input  logic [W-1:0] cap_b,
  input  logic         cap_vld,
  output logic [W-1:0] code0,
  output logic [W-1:0] code1,
  output logic         upd
);
  logic load;

  assign load = out_en && cap_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      code0 <= '0;
      code1 <= '0;
      upd   <= 1'b0;
    end else begin
      upd <= load;
      if (load) begin
        code0 <= cap_a;
        code1 <= cap_b;
      end
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> ($stable(code0) && $stable(code1))); // R7
  AST_STROBE_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !upd); // R7
  AST_STROBE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (out_en && cap_vld) |=> upd); // R8
endmodule

// File: rtl/twin_sample_front.sv
module twin_sample_front
  import twin_sample_pkg::*;
#(
  parameter int W = DEF_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         il_mode,
  input  logic         out_en,
  input  logic [W-1:0] bus0,
  input  logic [W-1:0] bus1,
  output logic [W-1:0] code0,
  output logic [W-1:0] code1,
  output logic         upd
);
  logic [W-1:0] cap_a;
  logic [W-1:0] cap_b;
  logic         cap_vld;

  twin_sample_capture #(.W(W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .il_mode (il_mode),
    .bus0    (bus0),
    .bus1    (bus1),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .cap_vld (cap_vld)
  );

  twin_sample_outreg #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .out_en  (out_en),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .cap_vld (cap_vld),
    .code0   (code0),
    .code1   (code1),
    .upd     (upd)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (code0 == '0 && code1 == '0 && !upd)); // R1
  AST_CH0_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !rst ##1 out_en |=> code0 == $past(bus0, 2)); // R2
  AST_CH1_PARALLEL: assert property (@(posedge clk) disable iff (rst)
    (!rst && !il_mode) ##1 out_en |=> code1 == $past(bus1, 2)); // R2
endmodule

// File: tb/tb_twin_sample_front.sv
`timescale 1ns/1ps
module tb_twin_sample_front;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         il_mode = 1'b0;
  logic         out_en = 1'b1;
  logic [W-1:0] bus0 = '0;
  logic [W-1:0] bus1 = '0;
  logic [W-1:0] code0;
  logic [W-1:0] code1;
  logic         upd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_sample_front #(.W(W)) dut (
    .clk(clk), .rst(rst), .il_mode(il_mode), .out_en(out_en),
    .bus0(bus0), .bus1(bus1), .code0(code0), .code1(code1), .upd(upd)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    check("R1 code0", code0, 8'h00);
    check("R1 code1", code1, 8'h00);
    check("R1 upd", {7'b0, upd}, 8'h00);
    bus0 = 8'h5A; bus1 = 8'hA5;
    rst = 1'b0;
    step();
    check("R8 no strobe before first capture", {7'b0, upd}, 8'h00);
    step();
    check("R8 first strobe", {7'b0, upd}, 8'h01);
    check("R2 first code0", code0, 8'h5A);
    check("R2 first code1", code1, 8'hA5);
  endtask

  task automatic t_parallel_single();
    il_mode = 1'b0; out_en = 1'b1;
    step();
    bus0 = 8'hFF; bus1 = 8'h00;
    step();
    bus0 = 8'h12; bus1 = 8'h34;
    check("R2 not yet code0", code0, 8'h5A);
    step();
    check("R2 code0", code0, 8'hFF);
    check("R2 code1", code1, 8'h00);
  endtask

  task automatic t_parallel_stream();
    logic [W-1:0] pa [6];
    logic [W-1:0] pb [6];
    il_mode = 1'b0; out_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pa[i] = 8'(8'h11 * i + 3);
      pb[i] = 8'(8'hF0 - 8'h13 * i);
    end
    for (int i = 0; i < 6; i++) begin
      bus0 = pa[i]; bus1 = pb[i];
      step();
      if (i >= 1) begin
        check("R3 stream code0", code0, pa[i-1]);
        check("R3 stream code1", code1, pb[i-1]);
        check("R8 stream upd", {7'b0, upd}, 8'h01);
      end
    end
    step();
    check("R3 last code0", code0, pa[5]);
    check("R3 last code1", code1, pb[5]);
  endtask

  task automatic t_interleave();
    logic [W-1:0] va [5];
    logic [W-1:0] vb [5];
    logic [W-1:0] o0, o1;
    il_mode = 1'b1; out_en = 1'b1;
    step(); step();
    for (int i = 0; i < 5; i++) begin
      va[i] = 8'(8'h21 * i + 8'h0C);
      vb[i] = 8'(8'hC3 ^ (8'h1D * i));
    end
    for (int i = 0; i < 5; i++) begin
      o0 = code0; o1 = code1;
      bus0 = vb[i]; bus1 = 8'(8'h77 + i);
      @(negedge clk); #1;
      check("R9 no falling change code0", code0, o0);
      check("R9 no falling change code1", code1, o1);
      bus0 = va[i]; bus1 = 8'(8'hE1 - i);
      step();
      if (i >= 1) begin
        check("R5 il code0", code0, va[i-1]);
        check("R4 il code1", code1, vb[i-1]);
        check("R6 bus1 ignored code1", code1, vb[i-1]);
      end
    end
    bus1 = 8'h3C;
    step();
    check("R5 il last code0", code0, va[4]);
    check("R4 il last code1", code1, vb[4]);
  endtask

  task automatic t_standby();
    il_mode = 1'b0; out_en = 1'b1;
    bus0 = 8'h81; bus1 = 8'h7E;
    step(); step(); step();
    check("R2 pre-standby code0", code0, 8'h81);
    out_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bus0 = 8'(8'h40 + i); bus1 = 8'(8'h90 + i);
      step();
      check("R7 hold code0", code0, 8'h81);
      check("R7 hold code1", code1, 8'h7E);
      check("R7 upd low", {7'b0, upd}, 8'h00);
    end
    out_en = 1'b1;
    step();
    check("R7 resume code0", code0, 8'h42);
    check("R7 resume code1", code1, 8'h92);
    check("R8 resume upd", {7'b0, upd}, 8'h01);
  endtask

  task automatic t_mid_reset();
    bus0 = 8'hDE; bus1 = 8'hAD;
    step();
    rst = 1'b1;
    step();
    check("R1 mid code0", code0, 8'h00);
    check("R1 mid code1", code1, 8'h00);
    check("R1 mid upd", {7'b0, upd}, 8'h00);
    rst = 1'b0;
    step();
    check("R8 post-reset no strobe", {7'b0, upd}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_parallel_single();
    t_parallel_stream();
    t_interleave();
    t_standby();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule